// File: doc/BRIEF.md
# Endpoint FIFO Space Allocator

This block hands out regions of a shared endpoint FIFO memory. The memory is split into fixed-size allocation units, and a bitmap with one bit per unit records which units are taken. A requester presents an endpoint's maximum packet size and a slot count. The block turns these into a number of units and searches the bitmap from the lowest unit upward for the first free run that is long enough. It returns the byte address of that run and marks the units as used. A release names a start unit and a unit count, and clears those bits.

A chip that moves data in both directions normally uses one instance for the transmit FIFO and a second for the receive FIFO. The size of one segment is the maximum packet size rounded up to a power of two. A region holds one more segment than the slot count. Typical slot settings are 2 for a controller that supports the 5 Gb/s link and 1 for a controller limited to 480 Mb/s. The block has no FIFO memory, data path or register bus. Requests and results travel over a level request input, a busy flag and one-cycle result pulses.

Top module: `fifo_space_alloc`

## Requirements
- R1: After reset, busy, grant and err are low and every unit is free, so the first allocation is granted at unit 0.
- R2: An allocation needs ceil((slot + 1) * P / UNIT_BYTES) units, with a minimum of 1. P is the smallest power of two that is at least the max packet size, and a max packet size of 0 gives P = 1. This count appears on grant_units.
- R3: The granted start unit is the lowest index s at which units s .. s+need-1 are all free and s + need <= MAP_BITS.
- R4: On a grant, grant_addr equals BASE_ADDR + grant_start * UNIT_BYTES.
- R5: Granted units are marked used. No later grant overlaps them until they are released.
- R6: When no free run fits, or the need exceeds MAP_BITS, err pulses for one cycle, grant stays low, and no unit changes state.
- R7: A release clears units rel_start .. rel_start+rel_count-1. Indices at or beyond MAP_BITS are dropped. Releasing units that are already free changes nothing else.
- R8: The search tests one candidate start per clock. After the cycle in which the request is taken, busy stays high for s+1 cycles when the grant is at unit s. On failure it stays high for MAP_BITS-need+1 cycles, or for 1 cycle if need > MAP_BITS.
- R9: Requests are taken only while busy is low, and alloc_req and rel_req raised during a search are ignored. If both are raised together while idle, the allocation is taken and the release is dropped.
- R10: grant and err are single-cycle pulses, and they are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request, taken when busy is low |
| alloc_maxp | input | MAXP_W | Endpoint max packet size in bytes |
| alloc_slot | input | SLOT_W | Slot count; region holds slot+1 segments |
| rel_req | input | 1 | Release request, taken when idle and alloc_req is low |
| rel_start | input | IDX_W | First unit to free |
| rel_count | input | IDX_W+1 | Number of units to free |
| busy | output | 1 | Search in progress |
| grant | output | 1 | One-cycle pulse: region granted |
| grant_addr | output | ADDR_W | Byte address of granted region |
| grant_start | output | IDX_W | First unit of granted region |
| grant_units | output | NEED_W | Units in granted region |
| err | output | 1 | One-cycle pulse: no free run fits |

## Verification
The bench goes after the size rounding at its edges. These cases are a max packet size of 0, exact powers of two and one byte above them. A design that rounds wrongly grants regions that are too small or too large. It also goes after runs that end exactly at the last unit, a full map, and requests larger than the whole map. A wrong end bound in the search would either grant past the end or report failure while space remains. Releases that reach past the end, or that repeat on units already free, are checked for leaving other units untouched. Requests raised during a search, and a release raised together with an allocation, are checked to be dropped. A design that took them would corrupt the map, and the next first-fit result would differ from the bench's model.

// File: rtl/fifo_alloc_pkg.sv
`timescale 1ns/1ps
package fifo_alloc_pkg;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

endpackage

// File: rtl/fifo_size_calc.sv
`timescale 1ns/1ps
// Turns a max packet size and slot count into a unit count.
module fifo_size_calc #(
  parameter int MAXP_W     = 16,
  parameter int SLOT_W     = 2,
  parameter int UNIT_BYTES = 512,
  parameter int NEED_W     = MAXP_W + SLOT_W + 1
) (
  input  logic [MAXP_W-1:0] maxp,
  input  logic [SLOT_W-1:0] slot,
  output logic [NEED_W-1:0] units
);
  localparam int UNIT_LG = $clog2(UNIT_BYTES);
  localparam int SEG_W   = MAXP_W + 1;
  localparam int SUM_W   = NEED_W + 1;

  // smallest power of two >= mp (mp = 0 gives 1)
  function automatic logic [SEG_W-1:0] seg_bytes(input logic [MAXP_W-1:0] mp);
    logic [SEG_W-1:0] p;
    p = SEG_W'(1);
    for (int i = 0; i < MAXP_W; i++) begin
      if ({1'b0, mp} > p) p = p << 1;
    end
    return p;
  endfunction

  function automatic logic [NEED_W-1:0] region_bytes(input logic [MAXP_W-1:0] mp,
                                                     input logic [SLOT_W-1:0] sl);
    logic [NEED_W-1:0] seg;
    logic [NEED_W-1:0] mul;
    seg = NEED_W'(seg_bytes(mp));
    mul = NEED_W'(sl) + NEED_W'(1);
    return seg * mul;
  endfunction

  function automatic logic [NEED_W-1:0] units_of(input logic [NEED_W-1:0] bytes);
    logic [SUM_W-1:0] padded;
    logic [SUM_W-1:0] cnt;
    padded = SUM_W'(bytes) + SUM_W'(UNIT_BYTES - 1);
    cnt    = padded >> UNIT_LG;
    if (cnt == '0) cnt = SUM_W'(1);
    return cnt[NEED_W-1:0];
  endfunction

  logic [NEED_W-1:0] region_w;

  always_comb begin
    region_w = region_bytes(maxp, slot);
    units    = units_of(region_w);
  end

endmodule

// File: rtl/fifo_unit_map.sv
`timescale 1ns/1ps
// One bit per allocation unit, with a run probe, a run set and a run clear.
module fifo_unit_map #(
  parameter int MAP_BITS = 128,
  parameter int IDX_W    = 7,
  parameter int CNT_W    = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W:0]   set_start,
  input  logic [CNT_W-1:0] set_cnt,
  input  logic             clr_en,
  input  logic [IDX_W:0]   clr_start,
  input  logic [CNT_W-1:0] clr_cnt,
  input  logic [IDX_W:0]   probe_start,
  input  logic [CNT_W-1:0] probe_cnt,
  output logic             probe_free
);

  function automatic logic in_run(input int idx, input int first, input int len);
    return (idx >= first) && (idx < first + len);
  endfunction

  logic [MAP_BITS-1:0] map_q;
  logic [MAP_BITS-1:0] set_mask;
  logic [MAP_BITS-1:0] clr_mask;
  logic [MAP_BITS-1:0] probe_mask;
  logic                probe_past_end;

  for (genvar g = 0; g < MAP_BITS; g++) begin : g_bit
    assign set_mask[g]   = set_en && in_run(g, int'(set_start), int'(set_cnt));
    assign clr_mask[g]   = clr_en && in_run(g, int'(clr_start), int'(clr_cnt));
    assign probe_mask[g] = in_run(g, int'(probe_start), int'(probe_cnt));
  end

  assign probe_past_end = (int'(probe_start) + int'(probe_cnt)) > MAP_BITS;
  assign probe_free     = !probe_past_end && ((map_q & probe_mask) == '0);

  // set has priority over clear (the control never raises both)
  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= (map_q & ~clr_mask) | set_mask;
  end

  // R5: the search only claims units the map holds as free
  p_set_only_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> ((map_q & set_mask) == '0));

  // R5: claimed units read as used afterwards
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((map_q & $past(set_mask)) == $past(set_mask)));

  // R7: released units read as free afterwards
  p_clr_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((map_q & $past(clr_mask)) == '0));

  // R6: with no set or clear the map holds its value
  p_map_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(map_q));

endmodule

// File: rtl/fifo_fit_scan.sv
`timescale 1ns/1ps
// First-fit search: one candidate start index per clock.
module fifo_fit_scan
  import fifo_alloc_pkg::*;
#(
  parameter int MAP_BITS = 128,
  parameter int IDX_W    = 7,
  parameter int NEED_W   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [NEED_W-1:0] need_in,
  input  logic              probe_free,
  output logic [IDX_W:0]    probe_start,
  output logic [NEED_W-1:0] probe_cnt,
  output logic              set_en,
  output logic              busy,
  output logic              grant,
  output logic [IDX_W-1:0]  grant_start,
  output logic [NEED_W-1:0] grant_units,
  output logic              err
);
  localparam int SUM_W = NEED_W + 1;

  scan_state_e       state_q;
  logic [IDX_W:0]    cand_q;
  logic [NEED_W-1:0] need_q;
  logic              hit;
  logic              last_cand;

  assign busy        = (state_q == SCAN_RUN);
  assign probe_start = cand_q;
  assign probe_cnt   = need_q;
  assign hit         = busy && probe_free;
  assign set_en      = hit;
  // no later candidate can fit once cand + need reaches the map end
  assign last_cand   = (SUM_W'(cand_q) + SUM_W'(need_q)) >= SUM_W'(MAP_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SCAN_IDLE;
      cand_q      <= '0;
      need_q      <= '0;
      grant       <= 1'b0;
      err         <= 1'b0;
      grant_start <= '0;
      grant_units <= '0;
    end else begin
      grant <= 1'b0;
      err   <= 1'b0;
      unique case (state_q)
        SCAN_IDLE: begin
          if (go) begin
            need_q  <= need_in;
            cand_q  <= '0;
            state_q <= SCAN_RUN;
          end
        end
        SCAN_RUN: begin
          if (hit) begin
            grant       <= 1'b1;
            grant_start <= cand_q[IDX_W-1:0];
            grant_units <= need_q;
            state_q     <= SCAN_IDLE;
          end else if (last_cand) begin
            err     <= 1'b1;
            state_q <= SCAN_IDLE;
          end else begin
            cand_q <= cand_q + 1'b1;
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  // R10: the two result pulses never coincide
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && err));

  // R10: a grant lasts one cycle
  p_grant_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  // R8: a search only ends with a result
  p_end_has_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (grant || err));

  // R5: a granted run stays inside the map
  p_grant_in_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ((SUM_W'(grant_start) + SUM_W'(grant_units)) <= SUM_W'(MAP_BITS)));

endmodule

// File: rtl/fifo_space_alloc.sv
`timescale 1ns/1ps
// Top: size calculation, unit map and first-fit search.
module fifo_space_alloc #(
  parameter int              MAP_BITS   = 128,
  parameter int              UNIT_BYTES = 512,
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              MAXP_W     = 16,
  parameter int              SLOT_W     = 2,
  localparam int             IDX_W      = (MAP_BITS > 1) ? $clog2(MAP_BITS) : 1,
  localparam int             NEED_W     = MAXP_W + SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [MAXP_W-1:0] alloc_maxp,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic              rel_req,
  input  logic [IDX_W-1:0]  rel_start,
  input  logic [IDX_W:0]    rel_count,
  output logic              busy,
  output logic              grant,
  output logic [ADDR_W-1:0] grant_addr,
  output logic [IDX_W-1:0]  grant_start,
  output logic [NEED_W-1:0] grant_units,
  output logic              err
);
  localparam int UNIT_LG = $clog2(UNIT_BYTES);

  logic              alloc_go;
  logic              rel_go;
  logic [NEED_W-1:0] need_w;
  logic [IDX_W:0]    probe_start;
  logic [NEED_W-1:0] probe_cnt;
  logic              probe_free;
  logic              set_en;

  // allocation wins when both requests arrive together
  assign alloc_go = alloc_req && !busy;
  assign rel_go   = rel_req && !alloc_req && !busy;

  fifo_size_calc #(
    .MAXP_W     (MAXP_W),
    .SLOT_W     (SLOT_W),
    .UNIT_BYTES (UNIT_BYTES),
    .NEED_W     (NEED_W)
  ) u_size (
    .maxp  (alloc_maxp),
    .slot  (alloc_slot),
    .units (need_w)
  );

  fifo_unit_map #(
    .MAP_BITS (MAP_BITS),
    .IDX_W    (IDX_W),
    .CNT_W    (NEED_W)
  ) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (set_en),
    .set_start   (probe_start),
    .set_cnt     (probe_cnt),
    .clr_en      (rel_go),
    .clr_start   ({1'b0, rel_start}),
    .clr_cnt     (NEED_W'(rel_count)),
    .probe_start (probe_start),
    .probe_cnt   (probe_cnt),
    .probe_free  (probe_free)
  );

  fifo_fit_scan #(
    .MAP_BITS (MAP_BITS),
    .IDX_W    (IDX_W),
    .NEED_W   (NEED_W)
  ) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (alloc_go),
    .need_in     (need_w),
    .probe_free  (probe_free),
    .probe_start (probe_start),
    .probe_cnt   (probe_cnt),
    .set_en      (set_en),
    .busy        (busy),
    .grant       (grant),
    .grant_start (grant_start),
    .grant_units (grant_units),
    .err         (err)
  );

  assign grant_addr = BASE_ADDR + (ADDR_W'(grant_start) << UNIT_LG);

  // R9: a search starts only from an accepted request
  p_start_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(alloc_req));

  // R9: no release is taken during a search
  p_no_rel_in_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rel_go);

endmodule

// File: tb/tb_fifo_space_alloc.sv
`timescale 1ns/1ps
module tb_fifo_space_alloc;
  localparam int MAP  = 128;
  localparam int UNIT = 512;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic [15:0] alloc_maxp = '0;
  logic [1:0]  alloc_slot = '0;
  logic        rel_req = 1'b0;
  logic [6:0]  rel_start = '0;
  logic [7:0]  rel_count = '0;
  logic        busy, grant, err;
  logic [31:0] grant_addr;
  logic [6:0]  grant_start;
  logic [18:0] grant_units;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit [MAP-1:0] model = '0;

  always #2.5 clk = ~clk;

  fifo_space_alloc #(.BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_maxp(alloc_maxp),
    .alloc_slot(alloc_slot), .rel_req(rel_req), .rel_start(rel_start),
    .rel_count(rel_count), .busy(busy), .grant(grant), .grant_addr(grant_addr),
    .grant_start(grant_start), .grant_units(grant_units), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int b_units(input int maxp, input int slot);
    int seg, u;
    seg = 1;
    while (seg < maxp) seg = seg * 2;
    u = ((slot + 1) * seg) / UNIT;
    if (u * UNIT < (slot + 1) * seg) u++;
    if (u < 1) u = 1;
    return u;
  endfunction

  function automatic int b_first_fit(input int need);
    for (int s = 0; s + need <= MAP; s++) begin
      bit ok = 1'b1;
      for (int k = 0; k < need; k++) if (model[s + k]) ok = 1'b0;
      if (ok) return s;
    end
    return -1;
  endfunction

  // inject: 1 = requests during the search, 2 = release raised with the allocation
  task automatic do_alloc(input int maxp, input int slot, input int inject);
    int need, fit, cyc, exp_cyc, guard;
    bit got_g, got_e;
    need = b_units(maxp, slot);
    fit  = b_first_fit(need);
    @(negedge clk);
    alloc_req = 1'b1; alloc_maxp = 16'(maxp); alloc_slot = 2'(slot);
    if (inject == 2) begin rel_req = 1'b1; rel_start = 7'd0; rel_count = 8'd128; end
    @(negedge clk);
    alloc_req = 1'b0; rel_req = 1'b0;
    cyc = 0; guard = 0;
    while (!(grant || err) && guard < 400) begin
      if (busy) cyc++;
      if (inject == 1 && cyc == 1) begin
        rel_req = 1'b1; rel_start = 7'd0; rel_count = 8'd128; alloc_req = 1'b1;
      end else begin
        rel_req = 1'b0; alloc_req = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    rel_req = 1'b0; alloc_req = 1'b0;
    got_g = grant; got_e = err;
    chk(!(got_g && got_e), "R10 grant/err exclusive", got_e, 0);
    if (fit >= 0) begin
      exp_cyc = fit + 1;
      chk(got_g, "R5/R3 grant expected", got_g, 1);
      chk(grant_start == 7'(fit), "R3 first-fit start", grant_start, fit);
      chk(grant_units == 19'(need), "R2 unit count", grant_units, need);
      chk(grant_addr == BASE + 32'(fit * UNIT), "R4 granted address", grant_addr, BASE + fit * UNIT);
      for (int k = 0; k < need; k++) model[fit + k] = 1'b1;
    end else begin
      exp_cyc = (need > MAP) ? 1 : MAP - need + 1;
      chk(got_e, "R6 error expected", got_e, 1);
    end
    chk(cyc == exp_cyc, "R8 search cycles", cyc, exp_cyc);
    @(negedge clk);
    chk(!grant && !err, "R10 single-cycle pulse", grant | err, 0);
  endtask

  task automatic do_release(input int start, input int cnt);
    @(negedge clk);
    rel_req = 1'b1; rel_start = 7'(start); rel_count = 8'(cnt);
    @(negedge clk);
    rel_req = 1'b0;
    for (int k = 0; k < cnt; k++) if (start + k < MAP) model[start + k] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !grant && !err, "R1 outputs after reset", {busy, grant, err}, 0);

    // R2 rounding corners; R1 first grant at unit 0
    do_alloc(0, 0, 0);        // 1 unit at 0
    do_alloc(512, 0, 0);      // 1 unit at 1
    do_alloc(513, 1, 0);      // 1024*2 -> 4 units at 2
    do_alloc(1024, 2, 0);     // 6 units at 6
    do_alloc(65535, 3, 0);    // 512 units: R6 too big, 1 search cycle
    // R7: free the hole at 1, then first fit lands there
    do_release(1, 1);
    do_release(1, 1);         // R7 already free: harmless
    do_alloc(100, 0, 0);      // 1 unit at 1
    // R9: requests during search are ignored
    do_alloc(2048, 1, 1);     // 8 units at 12
    // R9: release raised with allocation is dropped
    do_alloc(64, 0, 2);       // 1 unit at 20
    // R7: clear all, clamp past end
    do_release(0, 128);
    do_release(100, 128);
    // full map exactly, then R6 failure with a long search
    do_alloc(16384, 3, 0);    // 128 units at 0
    do_alloc(1, 0, 0);        // err, 128 cycles
    do_release(127, 1);
    do_alloc(1, 0, 0);        // last unit, R3 run ending at map end
    do_alloc(1, 0, 0);        // err again
    do_release(0, 128);

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int r, mp;
      r = $urandom % 3;
      if (r < 2) begin
        case ($urandom % 4)
          0: mp = $urandom % 65;
          1: mp = $urandom % 1025;
          2: mp = $urandom % 4097;
          default: mp = $urandom % 16385;
        endcase
        do_alloc(mp, $urandom % 4, ($urandom % 8 == 0) ? 1 : 0);
      end else begin
        do_release($urandom % MAP, $urandom % (MAP + 1));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule